// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block sits between a synchronous user port and a 256K x 16 asynchronous static RAM. It accepts one word-sized read or write at a time over a request/ready handshake. It turns each request into a cycle on the memory pins whose phases last a whole number of clocks. Each phase length is a parameter, taken from the nanosecond minimum it must meet and rounded up to clock cycles. The defaults assume a 10 ns clock.

A two-bit byte enable picks which byte lanes take part. Bit 0 drives the low-lane strobe, which covers data bits 7:0. Bit 1 drives the high-lane strobe, which covers bits 15:8. The data bus is split into an output value, an output enable and an input value, so a pad ring can build the tristate. Before any write, the controller waits a guard interval so that data the memory may still be driving from an earlier read has floated off. It turns its own drivers on only after that wait. All memory pins come straight from flip-flops.

Top module: `sram_lane_ctrl`

## Requirements
- R1: During and after reset, until the first request, `ready` is 1, `rvalid` is 0, `mem_dq_oe` is 0, and chip select, output enable, write enable and both lane strobes are all high.
- R2: `ready` is 1 only while no cycle is in progress. A request is taken only on a clock edge where `req` and `ready` are both 1. A request raised while `ready` is 0 is ignored: no second memory cycle follows from it.
- R3: A write with a nonzero byte enable holds chip select low and output enable high for the whole cycle. It drives write enable low for exactly `T_WPULSE` consecutive cycles, and write enable rises while chip select is still low.
- R4: After chip select falls for a write, the data drivers stay off for exactly `T_TURN` cycles before write enable falls. `mem_dq_oe` is never 1 while output enable is low.
- R5: During a write, `mem_dq_oe` is 1 with `mem_dq_o` equal to the request's write data for the `T_WPULSE` low cycles of write enable plus exactly one cycle after write enable rises. After that, chip select and the drivers are released together.
- R6: While chip select is low, the low-lane strobe is low if and only if byte enable bit 0 was set, and the high-lane strobe is low if and only if bit 1 was set. The strobes do not change during the cycle. Only enabled lanes of the memory word are altered by a write.
- R7: A read with a nonzero byte enable holds chip select and output enable low and write enable high for exactly `T_ACCESS` cycles. All strobes go high again in the cycle after that.
- R8: At the end of a read, `rdata` takes `mem_dq_i` for the enabled lanes and zero for the disabled lanes. `rvalid` is 1 for exactly one cycle, the first cycle in which chip select is high again.
- R9: A request with byte enable 00 never lowers chip select. As a write it leaves memory unchanged. As a read it gives `rvalid` in the next cycle with `rdata` equal to 0.
- R10: `mem_addr` equals the accepted request address and stays constant for as long as chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request, taken when ready is high |
| ready | output | 1 | Controller idle and able to accept a request |
| wr | input | 1 | 1 = write request, 0 = read request |
| addr | input | ADDR_W | Word address |
| wdata | input | 16 | Write data |
| be | input | 2 | Byte enable, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rdata | output | 16 | Read data, disabled lanes zero |
| rvalid | output | 1 | One-cycle strobe marking rdata valid |
| mem_addr | output | ADDR_W | Memory address pins |
| mem_dq_o | output | 16 | Data driven towards the memory |
| mem_dq_oe | output | 1 | Enable for the data drivers |
| mem_dq_i | input | 16 | Data received from the memory |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_lb_n | output | 1 | Low-lane strobe, active low |
| mem_ub_n | output | 1 | High-lane strobe, active low |

## Verification
A corrupted sequencer state shows up as a wrong phase length on the memory pins within one cycle cycle of the request. Examples are a write enable low pulse of the wrong length, a turnaround gap that is missing, or drivers that stay on after chip select rises. Each of these is counted cycle by cycle against the parameters. A stale byte-enable or address register shows as a strobe or address mismatch while chip select is low. It also shows later as wrong lanes in the bench's memory model, which is visible on the next read-back. Faults in the capture path show as rdata with non-zero disabled lanes, or as an rvalid that is not exactly one cycle long and aligned with the release of the strobes.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

    localparam int CLK_NS  = 10;
    localparam int DATA_W  = 16;
    localparam int LANE_W  = 8;
    localparam int LANES   = DATA_W / LANE_W;

    // cycles needed to cover a nanosecond minimum at CLK_NS
    function automatic int ns_to_cyc(input int ns);
        return (ns + CLK_NS - 1) / CLK_NS;
    endfunction

    localparam int DEF_TURN   = ns_to_cyc(20);  // bus float after output disable
    localparam int DEF_WPULSE = ns_to_cyc(45);  // covers pulse, cs/addr/lane to end of write
    localparam int DEF_ACCESS = ns_to_cyc(55);  // address access time

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_WTURN,
        SQ_WPULSE,
        SQ_WHOLD,
        SQ_READ
    } seq_state_t;

    typedef struct packed {
        logic             cs_n;
        logic             oe_n;
        logic             we_n;
        logic             dq_oe;
        logic [LANES-1:0] lane_n;
    } pin_set_t;

    localparam pin_set_t PINS_IDLE = '{cs_n: 1'b1, oe_n: 1'b1, we_n: 1'b1,
                                       dq_oe: 1'b0, lane_n: '1};

    function automatic pin_set_t pins_for(input seq_state_t s,
                                          input logic [LANES-1:0] en);
        pin_set_t p;
        p = PINS_IDLE;
        if (s != SQ_IDLE) begin
            p.cs_n   = 1'b0;
            p.lane_n = ~en;
        end
        case (s)
            SQ_WPULSE: begin p.we_n = 1'b0; p.dq_oe = 1'b1; end
            SQ_WHOLD:  p.dq_oe = 1'b1;
            SQ_READ:   p.oe_n  = 1'b0;
            default:   ;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/sram_cycle_timer.sv
module sram_cycle_timer #(
    parameter int MAX_CNT = 8,
    localparam int CW     = $clog2(MAX_CNT + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)             cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
    import sram_lane_pkg::*;
#(
    parameter int T_TURN   = DEF_TURN,
    parameter int T_WPULSE = DEF_WPULSE,
    parameter int T_ACCESS = DEF_ACCESS,
    localparam int TMAX    = (T_ACCESS > T_WPULSE) ?
                             ((T_ACCESS > T_TURN) ? T_ACCESS : T_TURN) :
                             ((T_WPULSE > T_TURN) ? T_WPULSE : T_TURN),
    localparam int CW      = $clog2(TMAX + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic             wr,
    input  logic [LANES-1:0] be,
    output logic             ready,
    output logic             accept,
    output logic             capture,
    output logic             null_read,
    output pin_set_t         pins
);
    seq_state_t       state, nxt;
    logic [LANES-1:0] be_q, be_sel;
    logic             t_load, t_done;
    logic [CW-1:0]    t_val;

    sram_cycle_timer #(.MAX_CNT(TMAX)) u_timer (
        .clk(clk), .rst(rst), .load(t_load), .load_val(t_val), .expired(t_done)
    );

    assign ready  = (state == SQ_IDLE);
    assign accept = req && ready;
    assign be_sel = accept ? be : be_q;

    always_comb begin
        nxt       = state;
        t_load    = 1'b0;
        t_val     = '0;
        capture   = 1'b0;
        null_read = 1'b0;
        case (state)
            SQ_IDLE: if (accept) begin
                if (be == '0) begin
                    null_read = !wr;
                end else if (wr) begin
                    nxt = SQ_WTURN;  t_load = 1'b1; t_val = CW'(T_TURN - 1);
                end else begin
                    nxt = SQ_READ;   t_load = 1'b1; t_val = CW'(T_ACCESS - 1);
                end
            end
            SQ_WTURN: if (t_done) begin
                nxt = SQ_WPULSE; t_load = 1'b1; t_val = CW'(T_WPULSE - 1);
            end
            SQ_WPULSE: if (t_done) nxt = SQ_WHOLD;
            SQ_WHOLD:  nxt = SQ_IDLE;
            SQ_READ: if (t_done) begin
                nxt = SQ_IDLE; capture = 1'b1;
            end
            default: nxt = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SQ_IDLE;
            be_q  <= '0;
            pins  <= PINS_IDLE;
        end else begin
            state <= nxt;
            be_q  <= be_sel;
            pins  <= pins_for(nxt, be_sel);
        end
    end

    // drivers never fight the memory's outputs
    p_bus_excl_r4: assert property (@(posedge clk) disable iff (rst)
        pins.dq_oe |-> pins.oe_n);
    // write enable only inside chip select
    p_we_in_cs_r3: assert property (@(posedge clk) disable iff (rst)
        !pins.we_n |-> !pins.cs_n);
    // busy cycles never show ready
    p_ready_busy_r2: assert property (@(posedge clk) disable iff (rst)
        !pins.cs_n |-> !ready);
    // drivers kept one cycle past the rising write enable
    p_hold_after_we_r5: assert property (@(posedge clk) disable iff (rst)
        ($rose(pins.we_n) && !pins.cs_n) |-> pins.dq_oe);
    // lane strobes frozen while selected
    p_lane_stable_r6: assert property (@(posedge clk) disable iff (rst)
        (!pins.cs_n && $past(!pins.cs_n)) |-> $stable(pins.lane_n));
endmodule

// File: rtl/sram_lane_datapath.sv
module sram_lane_datapath
    import sram_lane_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              capture,
    input  logic              null_read,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [LANES-1:0]  be,
    input  logic [DATA_W-1:0] dq_i,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] dq_o,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);
    logic [LANES-1:0]  be_q;
    logic [DATA_W-1:0] masked;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign masked[g*LANE_W +: LANE_W] = be_q[g] ? dq_i[g*LANE_W +: LANE_W] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_addr <= '0;
            dq_o     <= '0;
            be_q     <= '0;
            rdata    <= '0;
            rvalid   <= 1'b0;
        end else begin
            if (accept) begin
                mem_addr <= addr;
                dq_o     <= wdata;
                be_q     <= be;
            end
            rvalid <= capture || null_read;
            if (capture)        rdata <= masked;
            else if (null_read) rdata <= '0;
        end
    end

    p_rvalid_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        rvalid |=> !rvalid);
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
    import sram_lane_pkg::*;
#(
    parameter int ADDR_W   = 18,
    parameter int T_TURN   = DEF_TURN,
    parameter int T_WPULSE = DEF_WPULSE,
    parameter int T_ACCESS = DEF_ACCESS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    output logic              ready,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [LANES-1:0]  be,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i,
    output logic              mem_cs_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_lb_n,
    output logic              mem_ub_n
);
    logic     accept, capture, null_read;
    pin_set_t pins;

    sram_seq_fsm #(
        .T_TURN(T_TURN), .T_WPULSE(T_WPULSE), .T_ACCESS(T_ACCESS)
    ) u_fsm (
        .clk(clk), .rst(rst), .req(req), .wr(wr), .be(be),
        .ready(ready), .accept(accept), .capture(capture),
        .null_read(null_read), .pins(pins)
    );

    sram_lane_datapath #(.ADDR_W(ADDR_W)) u_dp (
        .clk(clk), .rst(rst), .accept(accept), .capture(capture),
        .null_read(null_read), .addr(addr), .wdata(wdata), .be(be),
        .dq_i(mem_dq_i), .mem_addr(mem_addr), .dq_o(mem_dq_o),
        .rdata(rdata), .rvalid(rvalid)
    );

    assign mem_cs_n  = pins.cs_n;
    assign mem_oe_n  = pins.oe_n;
    assign mem_we_n  = pins.we_n;
    assign mem_dq_oe = pins.dq_oe;
    assign mem_lb_n  = pins.lane_n[0];
    assign mem_ub_n  = pins.lane_n[1];

    p_addr_stable_r10: assert property (@(posedge clk) disable iff (rst)
        (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));
endmodule

// File: tb/tb_sram_lane_ctrl.sv
module tb_sram_lane_ctrl;
    localparam int AW = 18;
    localparam int TT = 2;
    localparam int TW = 5;
    localparam int TA = 6;

    logic clk = 0, rst = 1;
    logic req = 0, wr = 0;
    logic [AW-1:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [1:0]  be = '0;
    logic ready, rvalid, mem_dq_oe, mem_cs_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n;
    logic [15:0] rdata, mem_dq_o, mem_dq_i;
    logic [AW-1:0] mem_addr;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic [15:0] model_mem [16];
    logic [15:0] shadow    [16];

    always #2.5 clk = ~clk;

    sram_lane_ctrl #(.ADDR_W(AW), .T_TURN(TT), .T_WPULSE(TW), .T_ACCESS(TA)) dut (
        .clk(clk), .rst(rst), .req(req), .ready(ready), .wr(wr), .addr(addr),
        .wdata(wdata), .be(be), .rdata(rdata), .rvalid(rvalid),
        .mem_addr(mem_addr), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
        .mem_dq_i(mem_dq_i), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n)
    );

    // behavioural memory: drives only enabled lanes, junk on the others
    always_comb begin
        mem_dq_i = 16'h5A5A;
        if (!mem_cs_n && !mem_oe_n && mem_we_n) begin
            if (!mem_lb_n) mem_dq_i[7:0]  = model_mem[mem_addr[3:0]][7:0];
            if (!mem_ub_n) mem_dq_i[15:8] = model_mem[mem_addr[3:0]][15:8];
        end
    end

    always @(posedge mem_we_n) begin
        if (!mem_cs_n && mem_dq_oe) begin
            if (!mem_lb_n) model_mem[mem_addr[3:0]][7:0]  = mem_dq_o[7:0];
            if (!mem_ub_n) model_mem[mem_addr[3:0]][15:8] = mem_dq_o[15:8];
        end
    end

    task automatic chk(input bit ok, input string req_tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req_tag, what, act, exp);
        end
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [15:0] d, input logic [1:0] b);
        int turn = 0, wlow = 0, drv = 0, cyc = 0, bad = 0, lbad = 0, abad = 0;
        bit first = 1;
        @(negedge clk);
        chk(ready == 1'b1, "R2", "ready before write", ready, 1);
        req = 1; wr = 1; addr = a; wdata = d; be = b;
        @(negedge clk);
        req = 0;
        if (b == 2'b00) begin
            for (int i = 0; i < 4; i++) begin
                if (mem_cs_n !== 1'b1) bad++;
                @(negedge clk);
            end
            chk(bad == 0, "R9", "cs low on empty write", bad, 0);
            return;
        end
        chk(ready == 1'b0, "R2", "ready while busy", ready, 0);
        while (!ready && cyc < 50) begin
            if (!mem_cs_n) begin
                if (!mem_oe_n) bad++;
                if (mem_lb_n != !b[0] || mem_ub_n != !b[1]) lbad++;
                if (mem_addr != a) abad++;
                if (mem_we_n && !mem_dq_oe && wlow == 0) turn++;
                if (!mem_we_n) wlow++;
                if (mem_dq_oe) begin
                    drv++;
                    if (mem_dq_o != d) bad++;
                end
            end else if (mem_dq_oe) bad++;
            first = 0;
            cyc++;
            @(negedge clk);
        end
        chk(bad == 0, "R3", "oe low or wrong data in write", bad, 0);
        chk(turn == TT, "R4", "turnaround cycles", turn, TT);
        chk(wlow == TW, "R3", "write pulse cycles", wlow, TW);
        chk(drv == TW + 1, "R5", "driver cycles", drv, TW + 1);
        chk(lbad == 0, "R6", "lane strobes", lbad, 0);
        chk(abad == 0, "R10", "address during write", abad, 0);
        chk(mem_cs_n && !mem_dq_oe, "R5", "release after write", {mem_cs_n, mem_dq_oe}, 2'b10);
        if (b[0]) shadow[a[3:0]][7:0]  = d[7:0];
        if (b[1]) shadow[a[3:0]][15:8] = d[15:8];
    endtask

    task automatic do_read(input logic [AW-1:0] a, input logic [1:0] b);
        int acc = 0, cyc = 0, lbad = 0, abad = 0;
        logic [15:0] exp;
        exp = shadow[a[3:0]] & {{8{b[1]}}, {8{b[0]}}};
        @(negedge clk);
        req = 1; wr = 0; addr = a; be = b;
        @(negedge clk);
        req = 0;
        while (!rvalid && cyc < 50) begin
            if (!mem_cs_n) begin
                if (!mem_oe_n && mem_we_n) acc++;
                if (mem_lb_n != !b[0] || mem_ub_n != !b[1]) lbad++;
                if (mem_addr != a) abad++;
            end
            cyc++;
            @(negedge clk);
        end
        if (b == 2'b00) chk(cyc == 0 && acc == 0, "R9", "empty read rvalid timing", cyc, 0);
        else            chk(acc == TA, "R7", "access cycles", acc, TA);
        chk(rvalid == 1'b1, "R8", "rvalid seen", rvalid, 1);
        chk(rdata == exp, "R8", "read data", rdata, exp);
        chk(mem_cs_n && mem_oe_n && mem_lb_n && mem_ub_n, "R7", "strobes high at rvalid",
            {mem_cs_n, mem_oe_n, mem_lb_n, mem_ub_n}, 4'hF);
        chk(lbad == 0 && abad == 0, "R6", "lanes/address during read", lbad + abad, 0);
        @(negedge clk);
        chk(rvalid == 1'b0, "R8", "rvalid single cycle", rvalid, 0);
    endtask

    task automatic busy_ignore();
        int extra = 0;
        @(negedge clk);
        req = 1; wr = 1; addr = 18'd5; wdata = 16'h1234; be = 2'b11;
        @(negedge clk);
        req = 0;
        @(negedge clk);
        req = 1; wr = 1; addr = 18'd6; wdata = 16'hFFFF; be = 2'b11;
        @(negedge clk);
        req = 0;
        while (!ready) @(negedge clk);
        shadow[5] = 16'h1234;
        for (int i = 0; i < 4; i++) begin
            if (!mem_cs_n) extra++;
            @(negedge clk);
        end
        chk(extra == 0, "R2", "cycle started from busy request", extra, 0);
        chk(model_mem[6] == shadow[6], "R2", "memory at ignored address", model_mem[6], shadow[6]);
    endtask

    task automatic reset_check();
        repeat (3) @(negedge clk);
        chk(ready && !rvalid && !mem_dq_oe && mem_cs_n && mem_oe_n && mem_we_n && mem_lb_n && mem_ub_n,
            "R1", "pins in reset", {ready, rvalid, mem_dq_oe, mem_cs_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n},
            8'b10011111);
        rst = 0;
        @(negedge clk);
        chk(ready && !rvalid && mem_cs_n && !mem_dq_oe, "R1", "idle after reset",
            {ready, rvalid, mem_cs_n, mem_dq_oe}, 4'b1010);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin model_mem[i] = 16'h0; shadow[i] = 16'h0; end
        reset_check();
        do_write(18'd1, 16'hBEEF, 2'b11);
        do_read(18'd1, 2'b11);
        do_write(18'd2, 16'hAAAA, 2'b11);
        do_write(18'd2, 16'h1155, 2'b01);
        do_write(18'd2, 16'h77CC, 2'b10);
        chk(model_mem[2] == 16'h7755, "R6", "lane merge in memory", model_mem[2], 16'h7755);
        do_read(18'd2, 2'b01);
        do_read(18'd2, 2'b10);
        do_write(18'd3, 16'hC0DE, 2'b11);
        do_write(18'd3, 16'hFFFF, 2'b00);
        chk(model_mem[3] == 16'hC0DE, "R9", "empty write leaves memory", model_mem[3], 16'hC0DE);
        do_read(18'd3, 2'b00);
        do_read(18'h3FFF3, 2'b11);
        busy_ignore();
        do_read(18'd5, 2'b11);
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule